// File: doc/BRIEF.md
# Quad Wiper Register Command Executor

This block sits behind a serial front end that has already framed and decoded each command. It keeps the live tap setting of four 64-position resistor ladders, plus a bank of four stored settings per ladder, and executes one decoded command per strobe. A command can read or write a live setting or a stored setting, copy between the two for one ladder or for all four at once, report whether a persistent save is still running, or arm a stepping mode. In stepping mode each later step strobe nudges the chosen ladder one tap up or down.

Each live setting is decoded into a one-hot select of 64 taps. Whenever a stored setting changes, the block pulses a commit request for an outside save timer. That timer reports back on a busy input, and while it is busy the block refuses further changes to stored settings. The stored settings are plain flops that start from a fixed power-up image.

Top module: `wiper_bank_exec`

## Requirements
- R1: After reset, stored slot r of ladder p holds (16p + 5r + 7) mod 64. On the first clock edge after reset is released, each live setting is loaded from slot 0 of its own ladder, giving 7, 23, 39 and 55 for ladders 0 to 3.
- R2: Opcode 4'b1010 writes dataIn[5:0] into the live setting of ladder potSel. Opcode 4'b1001 returns that live setting zero-extended to 8 bits on rdData, with rdValid high for exactly the cycle after the command.
- R3: Opcode 4'b1100 writes dataIn[5:0] into slot regSel of ladder potSel. Opcode 4'b1011 reads that slot, with the same timing as R2. Every accepted change to a slot pulses commitReq for the cycle after the command.
- R4: Opcode 4'b1101 copies slot regSel of ladder potSel into that ladder's live setting. Opcode 4'b1110 copies the live setting into that slot and pulses commitReq.
- R5: Opcode 4'b0001 loads every ladder's live setting from its own slot regSel. Opcode 4'b1000 stores every live setting into slot regSel of its own ladder and pulses commitReq. potSel is ignored by both.
- R6: Opcode 4'b0010 arms stepping for ladder potSel. While stepping is armed, each stepValid moves that live setting up one tap when stepUp is 1 and down one tap when stepUp is 0. The next command disarms it.
- R7: A step saturates: up from 63 stays at 63, and down from 0 stays at 0.
- R8: Opcode 4'b0101 returns a status byte whose bit 0 equals wipFlag and whose bits 7..1 are zero.
- R9: While wipFlag is 1, opcodes 4'b1100, 4'b1110 and 4'b1000 change no slot and raise no commitReq. Commands on live settings and reads still execute.
- R10: Any other opcode changes no state and produces neither rdValid nor commitReq.
- R11: The tapSel field for ladder p (bits p*64+63..p*64) is one-hot, with its single 1 at the bit whose index equals that ladder's live setting.
- R12: When cmdValid and stepValid are high in the same cycle, the command executes, the step is discarded, and stepping is disarmed unless the command is 4'b0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | One-cycle strobe for a decoded command |
| opcode | input | 4 | Command code |
| regSel | input | 2 | Stored slot index |
| potSel | input | 2 | Ladder index |
| dataIn | input | 8 | Write data; bits 5..0 are used |
| stepValid | input | 1 | One-cycle step strobe while stepping is armed |
| stepUp | input | 1 | Step direction: 1 up, 0 down |
| wipFlag | input | 1 | Save timer busy |
| rdValid | output | 1 | Read data valid |
| rdData | output | 8 | Read data |
| commitReq | output | 1 | Stored slot changed; start a save |
| wiperCode | output | 24 | Live settings, ladder p in bits p*6+5..p*6 |
| tapSel | output | 256 | One-hot tap selects, 64 per ladder |

## Verification
The collision that matters is a command strobe that arrives in the same cycle as a step strobe while stepping is armed. The command wins and the step is lost. The bench arms stepping on one ladder, moves it once, and then issues a read of that ladder together with a step. The queued read must return the value from before the collision. The live setting must not move, and a later lone step must also leave it alone because stepping is now disarmed. A second overlap, a busy save timer meeting a stored-slot write, is judged by the absence of commitReq and by reading back the untouched slot.

// File: rtl/wb_pkg.sv
package wb_pkg;
  parameter int WB_NPOT = 4;
  parameter int WB_NREG = 4;
  parameter int WB_BITS = 6;
  parameter int WB_BYTE = 8;
  localparam int WB_PB   = $clog2(WB_NPOT);
  localparam int WB_RB   = $clog2(WB_NREG);
  localparam int WB_NTAP = 1 << WB_BITS;

  typedef enum logic [3:0] {
    OP_RD_WIPER  = 4'b1001,
    OP_WR_WIPER  = 4'b1010,
    OP_RD_SLOT   = 4'b1011,
    OP_WR_SLOT   = 4'b1100,
    OP_SLOT2WIP  = 4'b1101,
    OP_WIP2SLOT  = 4'b1110,
    OP_GANG_LOAD = 4'b0001,
    OP_GANG_SAVE = 4'b1000,
    OP_STEP_ARM  = 4'b0010,
    OP_STATUS    = 4'b0101
  } wbOp_e;

  typedef struct packed {
    logic               bootLoad;
    logic               wrWiper;
    logic               wrSlot;
    logic               slotToWiper;
    logic               wiperToSlot;
    logic               gangLoad;
    logic               gangSave;
    logic               rdWiper;
    logic               rdSlot;
    logic               rdStatus;
    logic               step;
    logic               stepUp;
    logic [WB_PB-1:0]   pot;
    logic [WB_RB-1:0]   slot;
    logic [WB_BITS-1:0] value;
  } wbStrobes_t;

  function automatic logic [WB_BITS-1:0] powerUpImage(input int p, input int r);
    logic [31:0] raw;
    raw = 32'(16 * p + 5 * r + 7);
    return raw[WB_BITS-1:0];
  endfunction
endpackage

// File: rtl/wb_ctrl.sv
module wb_ctrl
  import wb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [3:0]         opcode,
  input  logic [WB_RB-1:0]   regSel,
  input  logic [WB_PB-1:0]   potSel,
  input  logic [WB_BYTE-1:0] dataIn,
  input  logic               stepValid,
  input  logic               stepUp,
  input  logic               wipFlag,
  output wbStrobes_t         strobes
);
  logic             bootPending;
  logic             armed;
  logic [WB_PB-1:0] armedPot;

  always_comb begin
    strobes       = '0;
    strobes.pot   = potSel;
    strobes.slot  = regSel;
    strobes.value = dataIn[WB_BITS-1:0];
    if (bootPending) begin
      strobes.bootLoad = 1'b1;
    end else if (cmdValid) begin
      case (opcode)
        OP_RD_WIPER:  strobes.rdWiper     = 1'b1;
        OP_WR_WIPER:  strobes.wrWiper     = 1'b1;
        OP_RD_SLOT:   strobes.rdSlot      = 1'b1;
        OP_WR_SLOT:   strobes.wrSlot      = !wipFlag;
        OP_SLOT2WIP:  strobes.slotToWiper = 1'b1;
        OP_WIP2SLOT:  strobes.wiperToSlot = !wipFlag;
        OP_GANG_LOAD: strobes.gangLoad    = 1'b1;
        OP_GANG_SAVE: strobes.gangSave    = !wipFlag;
        OP_STATUS:    strobes.rdStatus    = 1'b1;
        default:      ;
      endcase
    end else if (stepValid && armed) begin
      strobes.step   = 1'b1;
      strobes.stepUp = stepUp;
      strobes.pot    = armedPot;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootPending <= 1'b1;
      armed       <= 1'b0;
      armedPot    <= '0;
    end else begin
      bootPending <= 1'b0;
      if (!bootPending && cmdValid) begin
        armed    <= (opcode == OP_STEP_ARM);
        armedPot <= potSel;
      end
    end
  end

  // R12: a command in the step cycle suppresses the step
  p_step_dropped_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && stepValid) |-> !strobes.step);
endmodule

// File: rtl/wb_datapath.sv
module wb_datapath
  import wb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  wbStrobes_t                 ctl,
  input  logic                       wipFlag,
  output logic                       rdValid,
  output logic [WB_BYTE-1:0]         rdData,
  output logic                       commitReq,
  output logic [WB_NPOT*WB_BITS-1:0] wiperFlat
);
  localparam logic [WB_BITS-1:0] TOP_CODE = {WB_BITS{1'b1}};
  localparam int PADW = WB_BYTE - WB_BITS;

  logic [WB_BITS-1:0] wiper [WB_NPOT];
  logic [WB_BITS-1:0] bank  [WB_NPOT][WB_NREG];

  function automatic logic [WB_BITS-1:0] nudge(input logic [WB_BITS-1:0] cur, input logic up);
    if (up) return (cur == TOP_CODE) ? cur : cur + 1'b1;
    return (cur == '0) ? cur : cur - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < WB_NPOT; p++) begin
        wiper[p] <= '0;
        for (int r = 0; r < WB_NREG; r++) bank[p][r] <= powerUpImage(p, r);
      end
      rdValid   <= 1'b0;
      rdData    <= '0;
      commitReq <= 1'b0;
    end else begin
      rdValid   <= ctl.rdWiper | ctl.rdSlot | ctl.rdStatus;
      commitReq <= ctl.wrSlot | ctl.wiperToSlot | ctl.gangSave;
      if (ctl.rdWiper)       rdData <= {{PADW{1'b0}}, wiper[ctl.pot]};
      else if (ctl.rdSlot)   rdData <= {{PADW{1'b0}}, bank[ctl.pot][ctl.slot]};
      else if (ctl.rdStatus) rdData <= {{(WB_BYTE-1){1'b0}}, wipFlag};
      for (int p = 0; p < WB_NPOT; p++) begin
        if (ctl.bootLoad)      wiper[p] <= bank[p][0];
        else if (ctl.gangLoad) wiper[p] <= bank[p][ctl.slot];
        else if (WB_PB'(p) == ctl.pot) begin
          if (ctl.wrWiper)          wiper[p] <= ctl.value;
          else if (ctl.slotToWiper) wiper[p] <= bank[p][ctl.slot];
          else if (ctl.step)        wiper[p] <= nudge(wiper[p], ctl.stepUp);
        end
        if (ctl.gangSave) bank[p][ctl.slot] <= wiper[p];
        else if (WB_PB'(p) == ctl.pot) begin
          if (ctl.wrSlot)           bank[p][ctl.slot] <= ctl.value;
          else if (ctl.wiperToSlot) bank[p][ctl.slot] <= wiper[p];
        end
      end
    end
  end

  for (genvar gp = 0; gp < WB_NPOT; gp++) begin : g_flat
    assign wiperFlat[gp*WB_BITS +: WB_BITS] = wiper[gp];
  end

  // R6: live settings only move under a wiper-changing strobe
  p_wiper_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.bootLoad | ctl.gangLoad | ctl.wrWiper | ctl.slotToWiper | ctl.step)
    |=> $stable(wiperFlat));
  // R7: upward step at the top code leaves everything unchanged
  p_sat_top_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && ctl.stepUp && wiper[ctl.pot] == TOP_CODE) |=> $stable(wiperFlat));
  // R7: downward step at code zero leaves everything unchanged
  p_sat_bottom_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.stepUp && wiper[ctl.pot] == '0) |=> $stable(wiperFlat));
  // R8: status byte carries only the busy flag
  p_status_upper_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdStatus |=> (rdValid && rdData[WB_BYTE-1:1] == '0));
endmodule

// File: rtl/wb_tapdecode.sv
module wb_tapdecode
  import wb_pkg::*;
(
  input  logic [WB_NPOT*WB_BITS-1:0] codeFlat,
  output logic [WB_NPOT*WB_NTAP-1:0] tapFlat
);
  for (genvar gp = 0; gp < WB_NPOT; gp++) begin : g_pot
    assign tapFlat[gp*WB_NTAP +: WB_NTAP] =
      WB_NTAP'(1) << codeFlat[gp*WB_BITS +: WB_BITS];
  end
endmodule

// File: rtl/wiper_bank_exec.sv
module wiper_bank_exec
  import wb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  input  logic [3:0]                 opcode,
  input  logic [WB_RB-1:0]           regSel,
  input  logic [WB_PB-1:0]           potSel,
  input  logic [WB_BYTE-1:0]         dataIn,
  input  logic                       stepValid,
  input  logic                       stepUp,
  input  logic                       wipFlag,
  output logic                       rdValid,
  output logic [WB_BYTE-1:0]         rdData,
  output logic                       commitReq,
  output logic [WB_NPOT*WB_BITS-1:0] wiperCode,
  output logic [WB_NPOT*WB_NTAP-1:0] tapSel
);
  wbStrobes_t strobes;

  wb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .opcode(opcode),
    .regSel(regSel), .potSel(potSel), .dataIn(dataIn),
    .stepValid(stepValid), .stepUp(stepUp), .wipFlag(wipFlag),
    .strobes(strobes)
  );

  wb_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(strobes), .wipFlag(wipFlag),
    .rdValid(rdValid), .rdData(rdData), .commitReq(commitReq),
    .wiperFlat(wiperCode)
  );

  wb_tapdecode u_tap (.codeFlat(wiperCode), .tapFlat(tapSel));

  // R9: a busy save timer blocks the commit of a slot write
  p_busy_no_commit_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && wipFlag && opcode == OP_WR_SLOT) |=> !commitReq);

  for (genvar gp = 0; gp < WB_NPOT; gp++) begin : g_chk
    // R11: exactly one tap per ladder
    p_tap_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
      $countones(tapSel[gp*WB_NTAP +: WB_NTAP]) == 1);
  end
endmodule

// File: tb/tb_wiper_bank_exec.sv
module tb_wiper_bank_exec;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [3:0] opcode = '0;
  logic [1:0] regSel = '0, potSel = '0;
  logic [7:0] dataIn = '0;
  logic stepValid = 1'b0, stepUp = 1'b0, wipFlag = 1'b0;
  logic rdValid, commitReq;
  logic [7:0] rdData;
  logic [23:0] wiperCode;
  logic [255:0] tapSel;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int ew [4];

  typedef struct { int val; string tag; } expItem_t;
  expItem_t rdq [$];

  always #5 clk = ~clk;

  wiper_bank_exec dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .opcode(opcode),
    .regSel(regSel), .potSel(potSel), .dataIn(dataIn),
    .stepValid(stepValid), .stepUp(stepUp), .wipFlag(wipFlag),
    .rdValid(rdValid), .rdData(rdData), .commitReq(commitReq),
    .wiperCode(wiperCode), .tapSel(tapSel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expectRead(input int v, input string tag);
    expItem_t it;
    it.val = v; it.tag = tag;
    rdq.push_back(it);
  endtask

  task automatic issue(input logic [3:0] op, input int r, input int p, input int d,
                       input bit stp = 1'b0, input bit up = 1'b0);
    @(negedge clk);
    cmdValid = 1'b1; opcode = op; regSel = 2'(r); potSel = 2'(p); dataIn = 8'(d);
    stepValid = stp; stepUp = up;
    @(negedge clk);
    cmdValid = 1'b0; stepValid = 1'b0;
  endtask

  task automatic step(input bit up, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      stepValid = 1'b1; stepUp = up;
      @(negedge clk);
      stepValid = 1'b0;
    end
  endtask

  task automatic chkWipers(input string tag);
    for (int p = 0; p < 4; p++)
      chk(wiperCode[p*6 +: 6] == 6'(ew[p]), tag, int'(wiperCode[p*6 +: 6]), ew[p]);
  endtask

  task automatic chkTaps(input string tag);
    for (int p = 0; p < 4; p++) begin
      logic [63:0] want;
      want = 64'd1 << ew[p];
      chk(tapSel[p*64 +: 64] == want, tag, $countones(tapSel[p*64 +: 64]), 1);
    end
  endtask

  // monitor: pops the scoreboard whenever read data appears
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (rdq.size() == 0) chk(1'b0, "R2 unexpected read", int'(rdData), -1);
      else begin
        expItem_t it;
        it = rdq.pop_front();
        chk(rdData == 8'(it.val), it.tag, int'(rdData), it.val);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 power-up load from slot 0
    ew = '{7, 23, 39, 55};
    chkWipers("R1 boot load");
    chk(rdValid == 1'b0 && commitReq == 1'b0, "R1 idle outputs", int'(rdValid), 0);
    chkTaps("R11 taps after boot");

    // R2 live setting write and read
    issue(4'b1010, 0, 2, 42); ew[2] = 42;
    chkWipers("R2 write wiper");
    expectRead(42, "R2 read wiper");
    issue(4'b1001, 0, 2, 0);

    // R3 slot write, commit, read
    issue(4'b1100, 3, 1, 8'hD1);
    chk(commitReq == 1'b1, "R3 commit after slot write", int'(commitReq), 1);
    @(negedge clk);
    chk(commitReq == 1'b0, "R3 commit is one pulse", int'(commitReq), 0);
    expectRead(17, "R3 read written slot");
    issue(4'b1011, 3, 1, 0);
    expectRead(1, "R3 read power-up slot");
    issue(4'b1011, 2, 3, 0);

    // R4 single transfers
    issue(4'b1101, 3, 1, 0); ew[1] = 17;
    chkWipers("R4 slot to wiper");
    issue(4'b1110, 1, 2, 0);
    chk(commitReq == 1'b1, "R4 commit after wiper to slot", int'(commitReq), 1);
    expectRead(42, "R4 slot holds wiper");
    issue(4'b1011, 1, 2, 0);

    // R5 gang transfers
    issue(4'b1000, 2, 3, 0);
    chk(commitReq == 1'b1, "R5 commit after gang save", int'(commitReq), 1);
    expectRead(7, "R5 gang save pot0");
    issue(4'b1011, 2, 0, 0);
    expectRead(55, "R5 gang save pot3");
    issue(4'b1011, 2, 3, 0);
    issue(4'b1010, 0, 0, 9); issue(4'b1010, 0, 3, 30);
    issue(4'b0001, 2, 1, 0);
    chkWipers("R5 gang load");

    // R6 / R7 stepping
    issue(4'b0010, 0, 3, 0);
    step(1'b1, 3); ew[3] = 58; chkWipers("R6 step up");
    step(1'b0, 2); ew[3] = 56; chkWipers("R6 step down");
    step(1'b1, 10); ew[3] = 63; chkWipers("R7 saturate at 63");
    chkTaps("R11 taps at top");
    issue(4'b1010, 0, 0, 2); ew[0] = 2;
    issue(4'b0010, 0, 0, 0);
    step(1'b0, 5); ew[0] = 0; chkWipers("R7 saturate at 0");
    chkTaps("R11 taps at bottom");

    // R8 status
    expectRead(0, "R8 status idle");
    issue(4'b0101, 0, 0, 0);
    wipFlag = 1'b1;
    expectRead(1, "R8 status busy");
    issue(4'b0101, 0, 0, 0);

    // R9 busy blocks slot changes
    issue(4'b1100, 0, 0, 33);
    chk(commitReq == 1'b0, "R9 no commit on busy write", int'(commitReq), 0);
    issue(4'b1110, 0, 0, 0);
    chk(commitReq == 1'b0, "R9 no commit on busy copy", int'(commitReq), 0);
    issue(4'b1000, 0, 0, 0);
    chk(commitReq == 1'b0, "R9 no commit on busy gang", int'(commitReq), 0);
    expectRead(7, "R9 slot untouched while busy");
    issue(4'b1011, 0, 0, 0);
    issue(4'b1010, 0, 1, 20); ew[1] = 20;
    chkWipers("R9 wiper write while busy");
    wipFlag = 1'b0;

    // R10 unknown opcodes
    foreach (ew[i]) ;
    issue(4'b0000, 0, 1, 5);
    chk(rdValid == 1'b0 && commitReq == 1'b0, "R10 op 0000 silent", int'(rdValid), 0);
    issue(4'b0011, 1, 2, 5);
    issue(4'b1111, 2, 3, 5);
    chk(rdValid == 1'b0 && commitReq == 1'b0, "R10 op 1111 silent", int'(commitReq), 0);
    issue(4'b0111, 0, 0, 5);
    chkWipers("R10 wipers unchanged");
    expectRead(42, "R10 slot unchanged");
    issue(4'b1011, 1, 2, 0);
    step(1'b1, 1);
    chkWipers("R10 unknown op disarms stepping");

    // R12 command and step together
    issue(4'b0010, 0, 1, 0);
    step(1'b1, 1); ew[1] = 21;
    chkWipers("R12 armed step");
    expectRead(21, "R12 read beats step");
    issue(4'b1001, 0, 1, 0, 1'b1, 1'b1);
    chkWipers("R12 step dropped");
    step(1'b1, 1);
    chkWipers("R12 stepping disarmed");

    repeat (3) @(negedge clk);
    chk(rdq.size() == 0, "R2 all reads returned", rdq.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule